// File: doc/BRIEF.md
# Flash Program Suspend Controller

This block holds the mode of a banked flash memory model while a word program runs. The host can pause that program so that other locations can be read, and then let it continue. Commands arrive already decoded as single-cycle strobes. Each strobe carries a bank number. The program engine reports whether it is still busy. A hardware reset returns everything to normal reading.

The block has four states: `MODE_READ` (0), `MODE_PROG` (1), `MODE_SPEND` (2, suspend pending) and `MODE_SREAD` (3, suspended, reads allowed). The transitions are:

- start: READ to PROG on `pgm_start`.
- finish: PROG to READ when `pgm_busy` is low.
- suspend: PROG to SPEND on `cmd_susp` with the matching bank.
- settle: SPEND to SREAD after `SUSP_LAT` cycles.
- resume: SREAD to PROG on `cmd_resume` with the matching bank, provided no ID/CFI read is open.
- reset: any state to READ.

While suspended, the block flags a read of the address under program as invalid. It also withdraws the status-flag enable for that bank until the program resumes.

Top module: `flash_psusp_ctrl`

## Requirements
- R1: During and after an asynchronous reset (`rst_n` low), `mode` is 0, and `pgm_pause`, `stat_en` and `rd_invalid` are all 0. A reset in any state returns the block to mode 0 and forgets the suspended bank and address, so a later read of that address is not flagged.
- R2: In mode 0, `pgm_start` moves the block to mode 1 on the next clock and latches `pgm_bank`, `pgm_addr` and `pgm_accel`. In modes 1 and 2, `stat_en` is one-hot at bit `pgm_bank`; in modes 0 and 3 it is zero. In mode 1, `pgm_busy` low returns the block to mode 0.
- R3: In mode 1, a `cmd_susp` whose `cmd_bank` equals the latched bank moves the block to mode 2. `pgm_pause` is high from the first cycle of mode 2. A `cmd_susp` in mode 0 or mode 3 is ignored.
- R4: A `cmd_susp` or `cmd_resume` whose `cmd_bank` differs from the latched bank is ignored.
- R5: Mode 2 lasts exactly `SUSP_LAT` cycles and then becomes mode 3. Suspend and resume strobes in mode 2 have no effect.
- R6: In mode 3, `pgm_pause` stays high and `stat_en` is zero. `rd_invalid` is high exactly when `rd_bank` and `rd_addr` equal the latched bank and address. A read of any other bank or address in mode 3 is valid.
- R7: A resume that is accepted moves mode 3 to mode 1 on the next clock. In mode 1, `pgm_pause` falls and `stat_en` returns to the latched bank.
- R8: In mode 3, `cmd_id_enter` opens an ID/CFI read and `cmd_id_exit` closes it. A resume is refused while the read is open, including in the cycle of `cmd_id_exit`. The open read is dropped on leaving mode 3.
- R9: If `pgm_busy` is low in the same cycle as a valid suspend in mode 1, completion wins and the block goes to mode 0.
- R10: A program started with `pgm_accel` high can be suspended and resumed in the same way. While it is suspended (mode 2 or 3), `acc_hv` must stay high.
- R11: `pgm_start` outside mode 0 is ignored, and the latched bank and address keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| pgm_start | input | 1 | A word program begins |
| pgm_bank | input | BANK_W | Bank of the program |
| pgm_addr | input | ADDR_W | Address of the program |
| pgm_accel | input | 1 | Program runs in accelerated mode |
| pgm_busy | input | 1 | Program engine still working |
| acc_hv | input | 1 | Accelerating high-voltage enable |
| cmd_bank | input | BANK_W | Bank carried by a suspend or resume command |
| cmd_susp | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_id_enter | input | 1 | ID/CFI read opened |
| cmd_id_exit | input | 1 | ID/CFI read closed |
| rd_bank | input | BANK_W | Bank of the current array read |
| rd_addr | input | ADDR_W | Address of the current array read |
| mode | output | 2 | Current mode (0 read, 1 program, 2 suspend pending, 3 suspended) |
| pgm_pause | output | 1 | Pause request to the program engine |
| stat_en | output | NUM_BANKS | Status-flag enable, one bit per bank |
| rd_invalid | output | 1 | Current read targets the suspended address |

## Verification
The bench probes each bank gate with a command aimed at the wrong bank. A design that compared against the command's own previous bank, or that did not compare at all, would suspend or resume in that case. It counts the cycles spent in the pending state: an off-by-one counter shows up as `SUSP_LAT` ± 1. It sends a resume in the same cycle as the ID exit, which catches a design that looks at the next value of the ID state instead of the current one. It also drives program completion together with a suspend, and applies a reset while suspended. These two cases catch a wrong priority and a suspended address left behind by the reset.

// File: rtl/flash_psusp_pkg.sv
package flash_psusp_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_SPEND = 2'd2,
        MODE_SREAD = 2'd3
    } psusp_mode_e;
endpackage

// File: rtl/psusp_lat_cnt.sv
module psusp_lat_cnt #(
    parameter int SUSP_LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SUSP_LAT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psusp_tgt.sv
module psusp_tgt #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [BANK_W-1:0]    pgm_bank,
    input  logic [ADDR_W-1:0]    pgm_addr,
    input  logic                 pgm_accel,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 drive_stat,
    input  logic                 in_susp,
    output logic [BANK_W-1:0]    bank_q,
    output logic                 accel_q,
    output logic                 bank_hit,
    output logic                 rd_invalid,
    output logic [NUM_BANKS-1:0] stat_en
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= '0;
            addr_q  <= '0;
            accel_q <= 1'b0;
        end else if (load) begin
            bank_q  <= pgm_bank;
            addr_q  <= pgm_addr;
            accel_q <= pgm_accel;
        end
    end

    assign bank_hit   = (cmd_bank == bank_q);
    assign rd_invalid = in_susp && (rd_bank == bank_q) && (rd_addr == addr_q);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_stat
        assign stat_en[g] = drive_stat && (bank_q == BANK_W'(g));
    end
endmodule

// File: rtl/psusp_fsm.sv
module psusp_fsm
    import flash_psusp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pgm_start,
    input  logic        pgm_busy,
    input  logic        cmd_susp,
    input  logic        cmd_resume,
    input  logic        cmd_id_enter,
    input  logic        cmd_id_exit,
    input  logic        bank_hit,
    input  logic        lat_done,
    output psusp_mode_e state,
    output logic        id_act,
    output logic        latch_tgt,
    output logic        enter_pend,
    output logic        in_pend,
    output logic        in_susp,
    output logic        drive_stat,
    output logic        pause
);
    psusp_mode_e state_d;
    logic        id_d;

    always_comb begin
        state_d = state;
        id_d    = id_act;
        unique case (state)
            MODE_READ: begin
                if (pgm_start) state_d = MODE_PROG;
            end
            MODE_PROG: begin
                if (!pgm_busy)                 state_d = MODE_READ;
                else if (cmd_susp && bank_hit) state_d = MODE_SPEND;
            end
            MODE_SPEND: begin
                if (lat_done) state_d = MODE_SREAD;
            end
            MODE_SREAD: begin
                if (cmd_resume && bank_hit && !id_act) begin
                    state_d = MODE_PROG;
                    id_d    = 1'b0;
                end else if (cmd_id_exit) begin
                    id_d = 1'b0;
                end else if (cmd_id_enter) begin
                    id_d = 1'b1;
                end
            end
            default: state_d = MODE_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= MODE_READ;
            id_act <= 1'b0;
        end else begin
            state  <= state_d;
            id_act <= id_d;
        end
    end

    always_comb begin
        latch_tgt  = 1'b0;
        enter_pend = 1'b0;
        in_pend    = 1'b0;
        in_susp    = 1'b0;
        drive_stat = 1'b0;
        pause      = 1'b0;
        unique case (state)
            MODE_READ: begin
                latch_tgt = pgm_start;
            end
            MODE_PROG: begin
                drive_stat = 1'b1;
                enter_pend = (state_d == MODE_SPEND);
            end
            MODE_SPEND: begin
                drive_stat = 1'b1;
                in_pend    = 1'b1;
                pause      = 1'b1;
            end
            MODE_SREAD: begin
                in_susp = 1'b1;
                pause   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_psusp_ctrl.sv
module flash_psusp_ctrl
    import flash_psusp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    parameter int SUSP_LAT  = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pgm_start,
    input  logic [BANK_W-1:0]    pgm_bank,
    input  logic [ADDR_W-1:0]    pgm_addr,
    input  logic                 pgm_accel,
    input  logic                 pgm_busy,
    input  logic                 acc_hv,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 cmd_susp,
    input  logic                 cmd_resume,
    input  logic                 cmd_id_enter,
    input  logic                 cmd_id_exit,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [1:0]           mode,
    output logic                 pgm_pause,
    output logic [NUM_BANKS-1:0] stat_en,
    output logic                 rd_invalid
);
    psusp_mode_e       state;
    logic              id_act;
    logic              latch_tgt;
    logic              enter_pend;
    logic              in_pend;
    logic              in_susp;
    logic              drive_stat;
    logic              lat_done;
    logic              bank_hit;
    logic [BANK_W-1:0] bank_q;
    logic              accel_q;

    psusp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pgm_start    (pgm_start),
        .pgm_busy     (pgm_busy),
        .cmd_susp     (cmd_susp),
        .cmd_resume   (cmd_resume),
        .cmd_id_enter (cmd_id_enter),
        .cmd_id_exit  (cmd_id_exit),
        .bank_hit     (bank_hit),
        .lat_done     (lat_done),
        .state        (state),
        .id_act       (id_act),
        .latch_tgt    (latch_tgt),
        .enter_pend   (enter_pend),
        .in_pend      (in_pend),
        .in_susp      (in_susp),
        .drive_stat   (drive_stat),
        .pause        (pgm_pause)
    );

    psusp_lat_cnt #(.SUSP_LAT(SUSP_LAT)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (enter_pend),
        .run   (in_pend),
        .done  (lat_done)
    );

    psusp_tgt #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (latch_tgt),
        .pgm_bank   (pgm_bank),
        .pgm_addr   (pgm_addr),
        .pgm_accel  (pgm_accel),
        .cmd_bank   (cmd_bank),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .drive_stat (drive_stat),
        .in_susp    (in_susp),
        .bank_q     (bank_q),
        .accel_q    (accel_q),
        .bank_hit   (bank_hit),
        .rd_invalid (rd_invalid),
        .stat_en    (stat_en)
    );

    assign mode = state;
endmodule

// File: rtl/flash_psusp_chk.sv
module flash_psusp_chk #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode,
    input logic                 pgm_pause,
    input logic [NUM_BANKS-1:0] stat_en,
    input logic                 cmd_resume,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic                 id_act,
    input logic [BANK_W-1:0]    bank_q,
    input logic                 accel_q,
    input logic                 acc_hv
);
    a_r2_stat_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_en));

    a_r3_pause_in_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> pgm_pause);

    a_r4_suspend_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) == 2'd1) |-> ($past(cmd_bank) == bank_q));

    a_r5_sread_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> ($past(mode) == 2'd2 || $past(mode) == 2'd3));

    a_r6_quiet_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (stat_en == '0 && pgm_pause));

    a_r7_prog_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (stat_en != '0 && !pgm_pause));

    a_r8_resume_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) == 2'd3) |-> ($past(cmd_resume) && !$past(id_act)));

    a_r10_hv_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && accel_q) |-> acc_hv);
endmodule

bind flash_psusp_ctrl flash_psusp_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .pgm_pause  (pgm_pause),
    .stat_en    (stat_en),
    .cmd_resume (cmd_resume),
    .cmd_bank   (cmd_bank),
    .id_act     (id_act),
    .bank_q     (bank_q),
    .accel_q    (accel_q),
    .acc_hv     (acc_hv)
);

// File: tb/flash_psusp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_psusp_ctrl_bench;
    localparam int NB  = 4;
    localparam int AW  = 8;
    localparam int LAT = 8;
    localparam int BW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pgm_start = 0, pgm_accel = 0, pgm_busy = 0, acc_hv = 0;
    logic [BW-1:0] pgm_bank = '0, cmd_bank = '0, rd_bank = '0;
    logic [AW-1:0] pgm_addr = '0, rd_addr = '0;
    logic          cmd_susp = 0, cmd_resume = 0, cmd_id_enter = 0, cmd_id_exit = 0;
    logic [1:0]    mode;
    logic          pgm_pause, rd_invalid;
    logic [NB-1:0] stat_en;

    flash_psusp_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .SUSP_LAT(LAT)) u_flash_psusp_ctrl (
        .clk(clk), .rst_n(rst_n), .pgm_start(pgm_start), .pgm_bank(pgm_bank),
        .pgm_addr(pgm_addr), .pgm_accel(pgm_accel), .pgm_busy(pgm_busy),
        .acc_hv(acc_hv), .cmd_bank(cmd_bank), .cmd_susp(cmd_susp),
        .cmd_resume(cmd_resume), .cmd_id_enter(cmd_id_enter),
        .cmd_id_exit(cmd_id_exit), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .mode(mode), .pgm_pause(pgm_pause), .stat_en(stat_en),
        .rd_invalid(rd_invalid)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference model
    int m_mode = 0, m_bank = 0, m_addr = 0, m_left = 0;
    bit m_id = 0;
    bit m_valid_addr = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_bank = 0; m_addr = 0; m_id = 0; m_left = 0;
        end else begin
            case (m_mode)
                0: if (pgm_start) begin
                       m_mode = 1; m_bank = int'(pgm_bank); m_addr = int'(pgm_addr);
                   end
                1: if (!pgm_busy) m_mode = 0;
                   else if (cmd_susp && int'(cmd_bank) == m_bank) begin
                       m_mode = 2; m_left = LAT;
                   end
                2: begin
                       m_left--;
                       if (m_left == 0) m_mode = 3;
                   end
                default: begin
                    if (cmd_resume && int'(cmd_bank) == m_bank && !m_id) begin
                        m_mode = 1; m_id = 0;
                    end else if (cmd_id_exit) m_id = 0;
                    else if (cmd_id_enter) m_id = 1;
                end
            endcase
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            int e_stat, e_pause, e_inv;
            e_stat  = (m_mode == 1 || m_mode == 2) ? (1 << m_bank) : 0;
            e_pause = (m_mode >= 2) ? 1 : 0;
            e_inv   = (m_mode == 3 && int'(rd_bank) == m_bank && int'(rd_addr) == m_addr) ? 1 : 0;
            check(cur_req, "mode", int'(mode), m_mode);
            check(cur_req, "pgm_pause", int'(pgm_pause), e_pause);
            check(cur_req, "stat_en", int'(stat_en), e_stat);
            check(cur_req, "rd_invalid", int'(rd_invalid), e_inv);
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic start_prog(int b, int a, bit acc);
        pgm_start = 1; pgm_bank = BW'(b); pgm_addr = AW'(a); pgm_accel = acc; pgm_busy = 1;
        tick();
        pgm_start = 0;
    endtask

    task automatic pulse_susp(int b);
        cmd_susp = 1; cmd_bank = BW'(b); tick(); cmd_susp = 0;
    endtask

    task automatic pulse_resume(int b);
        cmd_resume = 1; cmd_bank = BW'(b); tick(); cmd_resume = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R1 reset state
        tick(3);
        check("R1", "reset mode", int'(mode), 0);
        check("R1", "reset pause", int'(pgm_pause), 0);
        rst_n = 1; tick();

        // R3 suspend ignored in read mode
        cur_req = "R3";
        pulse_susp(0);
        check("R3", "susp in read", int'(mode), 0);

        // R2 start program on bank 2
        cur_req = "R2";
        start_prog(2, 8'h35, 0);
        check("R2", "prog mode", int'(mode), 1);
        check("R2", "stat_en bank2", int'(stat_en), 4);

        // R11 second start ignored
        cur_req = "R11";
        start_prog(1, 8'h11, 0);
        check("R11", "bank kept", int'(stat_en), 4);

        // R4 wrong bank suspend
        cur_req = "R4";
        pulse_susp(1);
        check("R4", "wrong bank susp", int'(mode), 1);

        // R3 / R5 suspend with latency
        cur_req = "R3";
        pulse_susp(2);
        check("R3", "pend mode", int'(mode), 2);
        check("R3", "pause first cycle", int'(pgm_pause), 1);
        cur_req = "R5";
        cmd_resume = 1; cmd_susp = 1; cmd_bank = 2;
        tick(); n = 1;
        cmd_resume = 0; cmd_susp = 0;
        while (mode == 2 && n < 50) begin n++; tick(); end
        check("R5", "pend length", n, LAT);
        check("R5", "sread reached", int'(mode), 3);

        // R6 invalid marking
        cur_req = "R6";
        rd_bank = 2; rd_addr = 8'h35; #1;
        check("R6", "suspended addr invalid", int'(rd_invalid), 1);
        rd_addr = 8'h34; #1;
        check("R6", "other addr valid", int'(rd_invalid), 0);
        rd_bank = 1; rd_addr = 8'h35; #1;
        check("R6", "other bank valid", int'(rd_invalid), 0);
        check("R6", "stat_en off", int'(stat_en), 0);
        tick();

        // R3 suspend in suspend ignored, R4 resume wrong bank ignored
        cur_req = "R3";
        pulse_susp(2);
        check("R3", "susp in sread", int'(mode), 3);
        cur_req = "R4";
        pulse_resume(0);
        check("R4", "wrong bank resume", int'(mode), 3);

        // R8 id read gating
        cur_req = "R8";
        cmd_id_enter = 1; tick(); cmd_id_enter = 0;
        pulse_resume(2);
        check("R8", "resume with id open", int'(mode), 3);
        cmd_id_exit = 1; cmd_resume = 1; cmd_bank = 2; tick();
        cmd_id_exit = 0; cmd_resume = 0;
        check("R8", "resume on exit cycle", int'(mode), 3);

        // R7 resume accepted
        cur_req = "R7";
        pulse_resume(2);
        check("R7", "resumed mode", int'(mode), 1);
        check("R7", "pause dropped", int'(pgm_pause), 0);
        check("R7", "stat_en back", int'(stat_en), 4);

        // R2 completion
        cur_req = "R2";
        pgm_busy = 0; tick();
        check("R2", "done to read", int'(mode), 0);

        // R9 completion beats suspend
        cur_req = "R9";
        start_prog(1, 8'h20, 0);
        pgm_busy = 0; pulse_susp(1);
        check("R9", "completion wins", int'(mode), 0);

        // R10 accelerated program suspend/resume
        cur_req = "R10";
        acc_hv = 1;
        start_prog(3, 8'h7f, 1);
        pulse_susp(3);
        tick(LAT + 1);
        check("R10", "accel suspended", int'(mode), 3);
        pulse_resume(3);
        check("R10", "accel resumed", int'(mode), 1);
        pgm_busy = 0; tick(); acc_hv = 0;

        // R1 reset while suspended
        cur_req = "R1";
        start_prog(0, 8'h44, 0);
        pulse_susp(0);
        tick(LAT + 1);
        check("R1", "suspended before reset", int'(mode), 3);
        rst_n = 0; pgm_busy = 0; #1;
        check("R1", "async reset mode", int'(mode), 0);
        tick(2);
        rst_n = 1;
        rd_bank = 0; rd_addr = 8'h44;
        tick(2);
        check("R1", "old addr not flagged", int'(rd_invalid), 0);

        finish_run();
    end
endmodule